// File: doc/BRIEF.md
# Indexed Palette Colour Table with Sequenced Register Port

This block holds a colour lookup table with 256 normal entries and 4 overlay (cursor) entries, each made of an 8-bit red, green and blue component. Software reaches the table through a 32-bit register window of 16 bytes. It first writes a colour index into an address register, then streams colour components through a single data port. A three-phase sequencer steps through red, green and blue, and the index advances by itself after each complete triplet, so a whole palette loads with one address write followed by a stream of component writes. A second data port reaches the overlay entries through the two low bits of the same index.

On the pixel side, a lookup port turns an 8-bit index, or an overlay selector, into a 24-bit RGB value one clock later. A display pipeline uses this port to colour indexed pixels and cursor pixels.

Top module: `clut_regport`

## Requirements
- R1: A write to byte offset 0x0 loads the index from write data bits 31:24 and returns the component sequencer to red.
- R2: A write to offset 0x4 stores write data bits 31:24 into normal entry [index]. Successive writes fill red, then green, then blue.
- R3: After the blue access of a triplet (read or write, on either data port), the sequencer returns to red and the index increments modulo 256, so 255 wraps to 0.
- R4: A write to offset 0xC follows the same sequence but targets overlay entry 256 + index[1:0]. The normal entry at the index is left unchanged.
- R5: A read of offset 0x4 (normal) or 0xC (overlay) returns the current component in read data bits 31:24 with bits 23:0 zero. It steps the same sequencer that writes use. Read data is valid in the cycle after the access.
- R6: A read of offset 0x0 returns the index in bits 31:24 and does not move the sequencer.
- R7: After reset every entry is black (all components 0), except normal entry 255 and overlay entries 256 and 258, which are white (all components 0xFF). Read data resets to zero.
- R8: An access to offset 0x8, an access whose address bits 1:0 are not zero, or an access whose byte enables are not all four set, changes no state. A read of this kind returns zero.
- R9: When pix_valid is high, pix_rgb one cycle later holds {red, green, blue} of overlay entry 256 + pix_ovl_sel if pix_ovl_en is set, else of normal entry pix_index, and pix_rgb_valid is high. When pix_valid is low, pix_rgb holds its value and pix_rgb_valid is low.
- R10: A lookup issued in the same cycle as a component write to the same entry returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the 16-byte window |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data; index and components in bits 31:24 |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| pix_valid | input | 1 | Lookup request |
| pix_index | input | 8 | Normal table index for a lookup |
| pix_ovl_en | input | 1 | Selects an overlay entry for the lookup |
| pix_ovl_sel | input | 2 | Overlay entry number |
| pix_rgb | output | 24 | Looked-up colour {red, green, blue} |
| pix_rgb_valid | output | 1 | pix_rgb updated from a request in the previous cycle |

## Verification
The bench sweeps every normal entry through the streamed write port and reads each one back through the lookup port. It also streams six entries back through the read port across the 255-to-0 wrap. A design that increments after every component, or that does not wrap, lands data on the wrong entries. The bench places an address write in the middle of a triplet: a sequencer that is not reset there writes the next byte into green. It checks that overlay writes alias the low index bits and leave the normal entry untouched. It checks that partial byte enables, misaligned offsets and offset 0x8 neither move the index nor alter a colour. It checks that a lookup in the same cycle as a write returns the old colour, which a write-through read path would break.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } comp_ph_e;

  // Word offsets within the register window (byte offset >> 2)
  localparam logic [1:0] WOFS_INDEX = 2'd0;
  localparam logic [1:0] WOFS_NORM  = 2'd1;
  localparam logic [1:0] WOFS_OVL   = 2'd3;
endpackage

// File: rtl/clut_rst_sync.sv
module clut_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/clut_decode.sv
module clut_decode
  import clut_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BE_W   = 4
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  output logic              acc_ok,
  output logic              idx_wr,
  output logic              idx_rd,
  output logic              comp_wr,
  output logic              comp_rd,
  output logic              comp_ovl
);
  logic [1:0] word_ofs;
  logic       aligned;
  logic       full_word;
  logic       is_norm;
  logic       is_ovl;

  always_comb begin
    word_ofs  = bus_addr[3:2];
    aligned   = (bus_addr[1:0] == 2'b00);
    full_word = (bus_be == {BE_W{1'b1}});
    acc_ok    = bus_sel && aligned && full_word;
    is_norm   = (word_ofs == WOFS_NORM);
    is_ovl    = (word_ofs == WOFS_OVL);
    idx_wr    = acc_ok &&  bus_wr && (word_ofs == WOFS_INDEX);
    idx_rd    = acc_ok && !bus_wr && (word_ofs == WOFS_INDEX);
    comp_wr   = acc_ok &&  bus_wr && (is_norm || is_ovl);
    comp_rd   = acc_ok && !bus_wr && (is_norm || is_ovl);
    comp_ovl  = is_ovl;
  end
endmodule

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_load,
  input  logic [IDX_W-1:0] idx_val,
  input  logic             advance,
  output logic [IDX_W-1:0] idx_q,
  output comp_ph_e         ph_q
);
  logic [IDX_W-1:0] idx_d;
  comp_ph_e         ph_d;
  logic             seq_en;

  always_comb begin
    idx_d  = idx_q;
    ph_d   = ph_q;
    seq_en = idx_load || advance;
    if (idx_load) begin
      idx_d = idx_val;
      ph_d  = PH_RED;
    end else if (advance) begin
      case (ph_q)
        PH_RED:  ph_d = PH_GRN;
        PH_GRN:  ph_d = PH_BLU;
        default: begin
          ph_d  = PH_RED;
          idx_d = idx_q + 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ph_q  <= PH_RED;
    end else if (seq_en) begin
      idx_q <= idx_d;
      ph_q  <= ph_d;
    end
  end

  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_load |=> (ph_q == PH_RED) && (idx_q == $past(idx_val)));

  // R3
  triplet_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !idx_load && ph_q == PH_BLU) |=>
      (ph_q == PH_RED) && (idx_q == $past(idx_q) + 1'b1));

  // R3
  mid_triplet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !idx_load && ph_q != PH_BLU) |=> $stable(idx_q));
endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int OVL_W  = 2,
  parameter int COMP_W = 8,
  parameter int ENT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ENT_W-1:0]  wr_ent,
  input  comp_ph_e          wr_ph,
  input  logic [COMP_W-1:0] wr_data,
  input  logic [ENT_W-1:0]  rd_ent,
  input  comp_ph_e          rd_ph,
  output logic [COMP_W-1:0] rd_data,
  input  logic              pix_valid,
  input  logic [ENT_W-1:0]  pix_ent,
  output logic [3*COMP_W-1:0] pix_rgb,
  output logic              pix_rgb_valid
);
  localparam int NORM  = 1 << IDX_W;
  localparam int OVL   = 1 << OVL_W;
  localparam int DEPTH = NORM + OVL;
  localparam int RGB_W = 3 * COMP_W;

  logic [DEPTH-1:0][RGB_W-1:0] ent_flat;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    localparam bit WHITE = (e == NORM - 1) || (e == NORM) || (e == NORM + 2);
    localparam logic [RGB_W-1:0] RST_V = WHITE ? {RGB_W{1'b1}} : {RGB_W{1'b0}};

    logic [RGB_W-1:0] ent_q;
    logic [RGB_W-1:0] ent_d;
    logic             ent_en;

    always_comb begin
      ent_en = wr_en && (wr_ent == ENT_W'(e));
      ent_d  = ent_q;
      case (wr_ph)
        PH_RED:  ent_d[RGB_W-1 -: COMP_W]  = wr_data;
        PH_GRN:  ent_d[2*COMP_W-1 -: COMP_W] = wr_data;
        default: ent_d[COMP_W-1:0]         = wr_data;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= RST_V;
      else if (ent_en) ent_q <= ent_d;
    end

    assign ent_flat[e] = ent_q;
  end

  logic [RGB_W-1:0] rd_rgb;

  always_comb begin
    rd_rgb = ent_flat[rd_ent];
    case (rd_ph)
      PH_RED:  rd_data = rd_rgb[RGB_W-1 -: COMP_W];
      PH_GRN:  rd_data = rd_rgb[2*COMP_W-1 -: COMP_W];
      default: rd_data = rd_rgb[COMP_W-1:0];
    endcase
  end

  logic [RGB_W-1:0] pix_rgb_d;

  always_comb begin
    pix_rgb_d = ent_flat[pix_ent];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pix_rgb <= '0;
    else if (pix_valid) pix_rgb <= pix_rgb_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_rgb_valid <= 1'b0;
    else        pix_rgb_valid <= pix_valid;
  end

  // R9
  pix_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> pix_rgb_valid);

  // R9
  pix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !pix_rgb_valid && $stable(pix_rgb));
endmodule

// File: rtl/clut_regport.sv
module clut_regport
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int OVL_W  = 2,
  parameter int COMP_W = 8,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W/8-1:0]  bus_be,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic                pix_valid,
  input  logic [IDX_W-1:0]    pix_index,
  input  logic                pix_ovl_en,
  input  logic [OVL_W-1:0]    pix_ovl_sel,
  output logic [3*COMP_W-1:0] pix_rgb,
  output logic                pix_rgb_valid
);
  localparam int NORM  = 1 << IDX_W;
  localparam int DEPTH = NORM + (1 << OVL_W);
  localparam int ENT_W = $clog2(DEPTH);
  localparam int BE_W  = BUS_W / 8;

  logic rst_sync_n;

  clut_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic acc_ok, idx_wr, idx_rd, comp_wr, comp_rd, comp_ovl;

  clut_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_dec (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_be   (bus_be),
    .acc_ok   (acc_ok),
    .idx_wr   (idx_wr),
    .idx_rd   (idx_rd),
    .comp_wr  (comp_wr),
    .comp_rd  (comp_rd),
    .comp_ovl (comp_ovl)
  );

  logic [IDX_W-1:0] seq_idx;
  comp_ph_e         seq_ph;

  clut_seq #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .idx_load (idx_wr),
    .idx_val  (bus_wdata[BUS_W-1 -: IDX_W]),
    .advance  (comp_wr || comp_rd),
    .idx_q    (seq_idx),
    .ph_q     (seq_ph)
  );

  logic [ENT_W-1:0]  bus_ent;
  logic [ENT_W-1:0]  pix_ent;
  logic [COMP_W-1:0] rd_comp;

  always_comb begin
    bus_ent = comp_ovl ? (ENT_W'(NORM) + ENT_W'(seq_idx[OVL_W-1:0]))
                       : ENT_W'(seq_idx);
    pix_ent = pix_ovl_en ? (ENT_W'(NORM) + ENT_W'(pix_ovl_sel))
                         : ENT_W'(pix_index);
  end

  clut_store #(
    .IDX_W(IDX_W), .OVL_W(OVL_W), .COMP_W(COMP_W), .ENT_W(ENT_W)
  ) u_store (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .wr_en         (comp_wr),
    .wr_ent        (bus_ent),
    .wr_ph         (seq_ph),
    .wr_data       (bus_wdata[BUS_W-1 -: COMP_W]),
    .rd_ent        (bus_ent),
    .rd_ph         (seq_ph),
    .rd_data       (rd_comp),
    .pix_valid     (pix_valid),
    .pix_ent       (pix_ent),
    .pix_rgb       (pix_rgb),
    .pix_rgb_valid (pix_rgb_valid)
  );

  logic [BUS_W-1:0] rdata_d;
  logic             rdata_en;

  always_comb begin
    rdata_en = bus_sel && !bus_wr;
    rdata_d  = '0;
    if (idx_rd)       rdata_d = {seq_idx, {(BUS_W-IDX_W){1'b0}}};
    else if (comp_rd) rdata_d = {rd_comp, {(BUS_W-COMP_W){1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   bus_rdata <= '0;
    else if (rdata_en) bus_rdata <= rdata_d;
  end

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^bus_wdata[BUS_W-IDX_W-1:0];

  // R8
  ignored_access_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && !acc_ok) |=> $stable(seq_idx) && $stable(seq_ph));

  // R8
  ignored_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_sel && !bus_wr && !acc_ok) |=> (bus_rdata == '0));

  // R6
  index_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    idx_rd |=> (bus_rdata[BUS_W-1 -: IDX_W] == $past(seq_idx)) && $stable(seq_ph));
endmodule

// File: tb/tb_clut_regport.sv
module tb_clut_regport;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_index = '0;
  logic        pix_ovl_en = 1'b0;
  logic [1:0]  pix_ovl_sel = '0;
  logic [23:0] pix_rgb;
  logic        pix_rgb_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clut_regport dut (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pix_valid(pix_valid), .pix_index(pix_index), .pix_ovl_en(pix_ovl_en),
    .pix_ovl_sel(pix_ovl_sel), .pix_rgb(pix_rgb), .pix_rgb_valid(pix_rgb_valid)
  );

  function automatic logic [7:0] pat(input int i, input int c);
    return 8'((i * 37 + c * 101 + 13) & 255);
  endfunction

  function automatic logic [23:0] pat_rgb(input int i);
    return {pat(i, 0), pat(i, 1), pat(i, 2)};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic brd(input logic [3:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_be = be;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic look(input logic ovl, input logic [7:0] idx, output logic [23:0] rgb);
    @(negedge clk);
    pix_valid = 1; pix_ovl_en = ovl; pix_index = idx; pix_ovl_sel = idx[1:0];
    @(negedge clk);
    rgb = pix_rgb;
    n_chk++;
    if (pix_rgb_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL R9: pix_rgb_valid actual %b expected 1", pix_rgb_valid);
    end
    pix_valid = 0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [23:0] rgb;
    logic [23:0] held;

    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R7: reset contents and read data
    chk(bus_rdata, 32'h0, "R7 rdata");
    for (int i = 0; i < 256; i++) begin
      look(1'b0, 8'(i), rgb);
      chk({8'h0, rgb}, (i == 255) ? 32'hFFFFFF : 32'h0, "R7 normal");
    end
    for (int k = 0; k < 4; k++) begin
      look(1'b1, 8'(k), rgb);
      chk({8'h0, rgb}, (k == 0 || k == 2) ? 32'hFFFFFF : 32'h0, "R7 overlay");
    end

    // R6: index reads zero after reset
    brd(4'h0, 4'hF, d);
    chk(d, 32'h0, "R6 reset index");

    // R1 R2 R3: full sweep of normal entries from index 0
    bwr(4'h0, 32'h00AB_CDEF, 4'hF);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++)
        bwr(4'h4, {pat(i, c), 24'h5A5A5A}, 4'hF);
    brd(4'h0, 4'hF, d);
    chk(d, 32'h0, "R3 wrap after 256 triplets");
    for (int i = 0; i < 256; i++) begin
      look(1'b0, 8'(i), rgb);
      chk({8'h0, rgb}, {8'h0, pat_rgb(i)}, "R2 sweep");
    end

    // R5 R3: read six entries across the wrap
    bwr(4'h0, 32'hFA00_0000, 4'hF);
    brd(4'h0, 4'hF, d);
    chk(d, 32'hFA00_0000, "R6 index read");
    for (int j = 0; j < 6; j++)
      for (int c = 0; c < 3; c++) begin
        brd(4'h4, 4'hF, d);
        chk(d, {pat((250 + j) % 256, c), 24'h0}, "R5 read sequence");
      end
    brd(4'h0, 4'hF, d);
    chk(d, 32'h0000_0000, "R3 read wrap");

    // R4: overlay write via index 0x45 -> entry 257
    bwr(4'h0, 32'h4500_0000, 4'hF);
    bwr(4'hC, 32'h1100_0000, 4'hF);
    bwr(4'hC, 32'h2200_0000, 4'hF);
    bwr(4'hC, 32'h3300_0000, 4'hF);
    look(1'b1, 8'd1, rgb);
    chk({8'h0, rgb}, 32'h00112233, "R4 overlay entry");
    look(1'b0, 8'h45, rgb);
    chk({8'h0, rgb}, {8'h0, pat_rgb(8'h45)}, "R4 normal untouched");
    brd(4'h0, 4'hF, d);
    chk(d, 32'h4600_0000, "R4 index advance");

    // R5: overlay read with index 0xFE -> entry 258 (white)
    bwr(4'h0, 32'hFE00_0000, 4'hF);
    for (int c = 0; c < 3; c++) begin
      brd(4'hC, 4'hF, d);
      chk(d, 32'hFF00_0000, "R5 overlay read");
    end

    // R1: address write mid-triplet resets to red
    bwr(4'h0, 32'h0A00_0000, 4'hF);
    bwr(4'h4, 32'h7700_0000, 4'hF);
    bwr(4'h0, 32'h0A00_0000, 4'hF);
    bwr(4'h4, 32'h8800_0000, 4'hF);
    bwr(4'h4, 32'h9900_0000, 4'hF);
    bwr(4'h4, 32'hAA00_0000, 4'hF);
    look(1'b0, 8'h0A, rgb);
    chk({8'h0, rgb}, 32'h008899AA, "R1 sequencer reset");

    // R8: ignored accesses
    bwr(4'h0, 32'h2000_0000, 4'hF);
    bwr(4'h8, 32'h5500_0000, 4'hF);
    bwr(4'h4, 32'h6600_0000, 4'h3);
    bwr(4'h5, 32'h6600_0000, 4'hF);
    bwr(4'h0, 32'h3000_0000, 4'h7);
    brd(4'h8, 4'hF, d);
    chk(d, 32'h0, "R8 read offset 8");
    brd(4'h4, 4'hE, d);
    chk(d, 32'h0, "R8 partial read");
    brd(4'h0, 4'hF, d);
    chk(d, 32'h2000_0000, "R8 index unchanged");
    look(1'b0, 8'h20, rgb);
    chk({8'h0, rgb}, {8'h0, pat_rgb(8'h20)}, "R8 entry unchanged");
    // sequencer still at red: a full triplet lands on entry 0x20
    bwr(4'h4, 32'h0100_0000, 4'hF);
    bwr(4'h4, 32'h0200_0000, 4'hF);
    bwr(4'h4, 32'h0300_0000, 4'hF);
    look(1'b0, 8'h20, rgb);
    chk({8'h0, rgb}, 32'h00010203, "R8 phase unchanged");

    // R10: lookup in same cycle as write returns old value
    bwr(4'h0, 32'h3000_0000, 4'hF);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 4'h4; bus_be = 4'hF; bus_wdata = 32'hEE00_0000;
    pix_valid = 1; pix_ovl_en = 0; pix_index = 8'h30;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; pix_valid = 0;
    chk({8'h0, pix_rgb}, {8'h0, pat_rgb(8'h30)}, "R10 old value");
    look(1'b0, 8'h30, rgb);
    chk({8'h0, rgb}, {8'h0, 8'hEE, pat(8'h30, 1), pat(8'h30, 2)}, "R10 new value");

    // R9: hold when no request
    held = pix_rgb;
    @(negedge clk);
    pix_index = 8'h00;
    repeat (3) @(negedge clk);
    chk({8'h0, pix_rgb}, {8'h0, held}, "R9 hold");
    chk({31'h0, pix_rgb_valid}, 32'h0, "R9 valid low");

    finish_run();
  end
endmodule